// File: doc/BRIEF.md
# Autonomous Memory Scrub Engine

This block walks a memory one word at a time. For each word it reads the corrected value from the error-correcting read path and writes that value back. Over time this clears the single-bit upsets that build up in the array. Before each scrub it warns the host. An active-low busy line falls first, and after a programmable lead time an active-low scrub strobe falls. While the strobe is low the scrub owns the array and host accesses must wait. When the strobe rises the busy line is held low for a short tail and then released.

In master mode the engine paces itself from a programmable interval. Its strobe output can fan out to other engines running in slave mode. In slave mode the engine starts a scrub only when an incoming strobe falls, and its busy output stays high.

A pointer holds the address being scrubbed and can be read at any time. A configuration write sets the pointer to all ones, so the first scrub afterwards lands on address 0. If the read path flags an error during a scrub, a sticky flag is raised and the faulty address is kept.

Top module: `scrub_engine`

## Requirements
- R1: After reset, busy_n_o and scrub_n_o are 1, mem_rd and mem_wr are 0, scrub_ptr is all ones and err_flag is 0.
- R2: In master mode busy_n_o is low for exactly LEAD_BASE + LEAD_STEP*cfg_lead_code cycles before scrub_n_o falls. With the defaults that is 4 cycles for code 0 and 14 cycles for code 5.
- R3: In master mode scrub_n_o stays low for exactly STROBE_CYC cycles (8 by default). mem_rd and mem_wr are raised only while scrub_n_o is low.
- R4: In master mode busy_n_o rises exactly TAIL_CYC cycles (3 by default) after scrub_n_o rises, and scrub_n_o is high whenever busy_n_o rises.
- R5: In master mode busy_n_o stays high for exactly RATE_UNIT*(cfg_rate_code+1) cycles between scrubs, and for the same count after a configuration write. With the defaults that is 16 cycles for code 0 and 48 for code 2.
- R6: A cfg_wr pulse sets scrub_ptr to all ones. Each scrub adds 1 to the pointer, wrapping to 0, before it accesses memory, and the scrub then uses mem_addr equal to scrub_ptr. The first scrub after a configuration write therefore uses address 0.
- R7: Each scrub raises mem_rd for one cycle and mem_wr in the next cycle at the same address. The value written is the mem_rdata seen during the read.
- R8: If mem_err is 1 during a scrub read, err_flag is set and err_addr holds that address. The flag stays set until the next cfg_wr, which clears it.
- R9: While cfg_scrub_off or cfg_bypass is 1, no scrub starts: busy_n_o stays high, there are no memory accesses and the pointer does not move.
- R10: In slave mode (is_slave=1) busy_n_o and scrub_n_o stay 1. Each falling edge on scrub_n_i starts exactly one scrub, and the engine waits for scrub_n_i to return high before it accepts another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_slave | input | 1 | 1 = slave mode, 0 = master mode |
| cfg_wr | input | 1 | One-cycle pulse when the configuration is written |
| cfg_rate_code | input | 4 | Scrub interval code |
| cfg_lead_code | input | 4 | Busy-to-strobe lead code |
| cfg_scrub_off | input | 1 | 1 disables scrubbing |
| cfg_bypass | input | 1 | 1 bypasses error correction and also disables scrubbing |
| scrub_n_i | input | 1 | Incoming scrub strobe (slave mode), active low |
| busy_n_o | output | 1 | Scrub warning, active low (master mode) |
| scrub_n_o | output | 1 | Scrub strobe, active low (master mode) |
| mem_rd | output | 1 | Scrub read request |
| mem_wr | output | 1 | Scrub write-back request |
| mem_addr | output | 19 | Scrub address |
| mem_wdata | output | 32 | Corrected word written back |
| mem_rdata | input | 32 | Corrected word from the error-correcting read path |
| mem_err | input | 1 | Error flag from the read path, valid while mem_rd is high |
| scrub_ptr | output | 19 | Readable scrub pointer |
| err_flag | output | 1 | Sticky scrub-error flag |
| err_addr | output | 19 | Address of the last scrub error |

## Verification
The assertions assume three things about the inputs. First, the mode input and the configuration fields change only while the engine is idle. Second, cfg_wr is never pulsed during a scrub. Third, the incoming slave strobe starts high after reset. The bench keeps to these rules: it applies a configuration only at the sampling point where busy_n_o has just returned high, or while scrubbing is disabled. It switches to slave mode only from an idle, disabled state. The read path is modelled as a pure function of mem_addr, so the corrected word for every address is known to the scoreboard in advance.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
   typedef enum logic [2:0] {
      SC_IDLE,
      SC_WARN,
      SC_READ,
      SC_WBACK,
      SC_HOLD,
      SC_TAIL
   } scrub_state_e;
endpackage

// File: rtl/scrub_timer.sv
module scrub_timer
   import scrub_pkg::*;
#(
   parameter int CW         = 4,
   parameter int RATE_UNIT  = 16,
   parameter int LEAD_BASE  = 4,
   parameter int LEAD_STEP  = 2,
   parameter int STROBE_CYC = 8,
   parameter int TAIL_CYC   = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  scrub_state_e   phase,
   input  logic           restart,
   input  logic [CW-1:0]  rate_code,
   input  logic [CW-1:0]  lead_code,
   output logic           expire
);
   localparam int NCODE    = 2 ** CW;
   localparam int MAX_RATE = RATE_UNIT * NCODE;
   localparam int MAX_LEAD = LEAD_BASE + LEAD_STEP * (NCODE - 1);
   localparam int MAX_A    = (MAX_RATE > MAX_LEAD) ? MAX_RATE : MAX_LEAD;
   localparam int MAX_B    = (STROBE_CYC > TAIL_CYC) ? STROBE_CYC : TAIL_CYC;
   localparam int MAX_ALL  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TW       = $clog2(MAX_ALL + 1);

   initial begin
      assert (CW >= 1) else $error("scrub_timer: CW must be at least 1");
      assert (RATE_UNIT >= 1) else $error("scrub_timer: RATE_UNIT must be at least 1");
      assert (LEAD_BASE >= 1) else $error("scrub_timer: LEAD_BASE must be at least 1");
      assert (STROBE_CYC >= 3) else $error("scrub_timer: STROBE_CYC must be at least 3");
      assert (TAIL_CYC >= 1) else $error("scrub_timer: TAIL_CYC must be at least 1");
   end

   logic [TW-1:0] rate_lut [NCODE];
   logic [TW-1:0] lead_lut [NCODE];

   for (genvar g = 0; g < NCODE; g++) begin : g_lut
      assign rate_lut[g] = TW'(RATE_UNIT * (g + 1));
      assign lead_lut[g] = TW'(LEAD_BASE + LEAD_STEP * g);
   end

   logic [TW-1:0] tick;
   logic [TW-1:0] limit;

   always_comb begin
      case (phase)
         SC_IDLE: limit = rate_lut[rate_code];
         SC_WARN: limit = lead_lut[lead_code];
         SC_HOLD: limit = TW'(STROBE_CYC - 2);
         SC_TAIL: limit = TW'(TAIL_CYC);
         default: limit = TW'(1);
      endcase
   end

   assign expire = (tick == limit - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tick <= '0;
      else if (restart) tick <= '0;
      else if (!expire) tick <= tick + TW'(1);
   end

   // the phase counter never passes the limit of the current phase (R2, R5)
   p_tick_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick <= limit - TW'(1) || restart || $changed(phase));
endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm
   import scrub_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         is_slave,
   input  logic         en,
   input  logic         cfg_wr,
   input  logic         expire,
   input  logic         scrub_n_i,
   output scrub_state_e state,
   output logic         restart,
   output logic         start,
   output logic         busy_n_o,
   output logic         scrub_n_o,
   output logic         mem_rd,
   output logic         mem_wr
);
   scrub_state_e nxt;
   logic         prev_n;
   logic         fall;

   assign fall = prev_n & ~scrub_n_i;

   always_comb begin
      nxt = state;
      case (state)
         SC_IDLE: begin
            if (en) begin
               if (is_slave) begin
                  if (fall) nxt = SC_READ;
               end else if (expire && !cfg_wr) begin
                  nxt = SC_WARN;
               end
            end
         end
         SC_WARN:  if (expire) nxt = SC_READ;
         SC_READ:  nxt = SC_WBACK;
         SC_WBACK: nxt = SC_HOLD;
         SC_HOLD: begin
            if (is_slave) begin
               if (scrub_n_i) nxt = SC_IDLE;
            end else if (expire) begin
               nxt = SC_TAIL;
            end
         end
         SC_TAIL:  if (expire) nxt = SC_IDLE;
         default:  nxt = SC_IDLE;
      endcase
   end

   assign restart = (nxt != state) || (state == SC_IDLE && (!en || cfg_wr));
   assign start   = (nxt == SC_READ) && (state != SC_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SC_IDLE;
         prev_n <= 1'b1;
      end else begin
         state  <= nxt;
         prev_n <= scrub_n_i;
      end
   end

   assign busy_n_o  = ~(~is_slave & (state != SC_IDLE));
   assign scrub_n_o = ~(~is_slave & (state == SC_READ || state == SC_WBACK || state == SC_HOLD));
   assign mem_rd    = (state == SC_READ);
   assign mem_wr    = (state == SC_WBACK);

   // the warning is already active when the strobe falls (R2)
   p_busy_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scrub_n_o) |-> !busy_n_o);
   // memory access only under the strobe in master mode (R3)
   p_access_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) && !is_slave |-> !scrub_n_o);
   // the warning is released only after the strobe (R4)
   p_tail_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n_o) |-> scrub_n_o);
   // a write-back directly follows its read (R7)
   p_wr_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd));
   // no scrub starts while disabled (R9)
   p_no_start_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> en);
   // a slave engine never enters the warning or tail phases (R10)
   p_slave_no_warn_r10: assert property (@(posedge clk) disable iff (!rst_n)
      is_slave && state == SC_IDLE |=> state != SC_WARN);
endmodule

// File: rtl/scrub_ptr.sv
module scrub_ptr #(
   parameter int AW = 19,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic          start,
   input  logic          cap,
   input  logic [DW-1:0] rdata,
   input  logic          rerr,
   output logic [AW-1:0] ptr,
   output logic [DW-1:0] wdata,
   output logic          err_flag,
   output logic [AW-1:0] err_addr
);
   initial begin
      assert (AW >= 2) else $error("scrub_ptr: AW must be at least 2");
      assert (DW >= 1) else $error("scrub_ptr: DW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '1;
         wdata    <= '0;
         err_flag <= 1'b0;
         err_addr <= '0;
      end else begin
         if (cfg_wr)     ptr <= '1;
         else if (start) ptr <= ptr + AW'(1);
         if (cap) wdata <= rdata;
         if (cfg_wr) begin
            err_flag <= 1'b0;
         end else if (cap && rerr) begin
            err_flag <= 1'b1;
            err_addr <= ptr;
         end
      end
   end

   // one step per scrub, wrapping from all ones to zero (R6)
   p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start && !cfg_wr |=> ptr == $past(ptr) + AW'(1));
   // a configuration write re-arms the pointer (R6)
   p_ptr_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> ptr == '1);
   // the error flag holds until the next configuration write (R8)
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !cfg_wr |=> err_flag);
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
   import scrub_pkg::*;
#(
   parameter int AW         = 19,
   parameter int DW         = 32,
   parameter int CW         = 4,
   parameter int RATE_UNIT  = 16,
   parameter int LEAD_BASE  = 4,
   parameter int LEAD_STEP  = 2,
   parameter int STROBE_CYC = 8,
   parameter int TAIL_CYC   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          is_slave,
   input  logic          cfg_wr,
   input  logic [CW-1:0] cfg_rate_code,
   input  logic [CW-1:0] cfg_lead_code,
   input  logic          cfg_scrub_off,
   input  logic          cfg_bypass,
   input  logic          scrub_n_i,
   output logic          busy_n_o,
   output logic          scrub_n_o,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_err,
   output logic [AW-1:0] scrub_ptr,
   output logic          err_flag,
   output logic [AW-1:0] err_addr
);
   scrub_state_e  state;
   logic          restart;
   logic          start;
   logic          expire;
   logic          en;
   logic [AW-1:0] ptr;

   assign en = ~cfg_scrub_off & ~cfg_bypass;

   scrub_timer #(
      .CW(CW), .RATE_UNIT(RATE_UNIT), .LEAD_BASE(LEAD_BASE),
      .LEAD_STEP(LEAD_STEP), .STROBE_CYC(STROBE_CYC), .TAIL_CYC(TAIL_CYC)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .phase(state), .restart(restart),
      .rate_code(cfg_rate_code), .lead_code(cfg_lead_code), .expire(expire)
   );

   scrub_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .is_slave(is_slave), .en(en), .cfg_wr(cfg_wr),
      .expire(expire), .scrub_n_i(scrub_n_i), .state(state), .restart(restart),
      .start(start), .busy_n_o(busy_n_o), .scrub_n_o(scrub_n_o),
      .mem_rd(mem_rd), .mem_wr(mem_wr)
   );

   scrub_ptr #(.AW(AW), .DW(DW)) i_ptr (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .start(start), .cap(mem_rd),
      .rdata(mem_rdata), .rerr(mem_err), .ptr(ptr), .wdata(mem_wdata),
      .err_flag(err_flag), .err_addr(err_addr)
   );

   assign mem_addr  = ptr;
   assign scrub_ptr = ptr;

   // the write-back targets the address that was just read (R7)
   p_wb_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $stable(mem_addr));
   // the pointer moves only when a scrub starts or on configuration (R9)
   p_ptr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !cfg_wr |=> $stable(scrub_ptr));
endmodule

// File: tb/test_scrub_engine.sv
module test_scrub_engine;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int STROBE = 8;
   localparam int TAIL   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        is_slave = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_rate_code = '0;
   logic [3:0]  cfg_lead_code = '0;
   logic        cfg_scrub_off = 1'b1;
   logic        cfg_bypass = 1'b0;
   logic        scrub_n_i = 1'b1;
   logic        busy_n_o, scrub_n_o, mem_rd, mem_wr, mem_err, err_flag;
   logic [18:0] mem_addr, scrub_ptr, err_addr;
   logic [31:0] mem_wdata, mem_rdata;

   logic        err_en = 1'b0;
   logic [18:0] err_at = '0;
   logic        slave_viol = 1'b0;
   logic        done = 1'b0;
   int          n_chk = 0;
   int          n_err = 0;
   logic [18:0] exp_q[$];

   always #2.5 clk = ~clk;

   function automatic logic [31:0] pat(input logic [18:0] a);
      return {a[12:0], a} ^ 32'hA5C3_0F17;
   endfunction

   assign mem_rdata = pat(mem_addr);
   assign mem_err   = err_en && (mem_addr == err_at);

   scrub_engine i_scrub_engine (
      .clk(clk), .rst_n(rst_n), .is_slave(is_slave), .cfg_wr(cfg_wr),
      .cfg_rate_code(cfg_rate_code), .cfg_lead_code(cfg_lead_code),
      .cfg_scrub_off(cfg_scrub_off), .cfg_bypass(cfg_bypass),
      .scrub_n_i(scrub_n_i), .busy_n_o(busy_n_o), .scrub_n_o(scrub_n_o),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
      .scrub_ptr(scrub_ptr), .err_flag(err_flag), .err_addr(err_addr)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: every write-back must match the next expected address
   always @(negedge clk) begin
      if (rst_n && mem_wr) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected scrub write at", mem_addr, 0);
         end else begin
            automatic logic [18:0] ea = exp_q.pop_front();
            check(mem_addr == ea, "R6", "scrub address", mem_addr, ea);
            check(mem_wdata == pat(ea), "R7", "write-back data", mem_wdata, pat(ea));
         end
      end
      if (rst_n && is_slave && (!busy_n_o || !scrub_n_o)) slave_viol = 1'b1;
   end

   task automatic cfg_pulse();
      @(negedge clk) cfg_wr = 1'b1;
      @(negedge clk) cfg_wr = 1'b0;
   endtask

   task automatic count_while_busy_hi(output int c);
      c = 0;
      while (busy_n_o && c < 5000) begin c++; @(negedge clk); end
   endtask

   task automatic run_master(input logic [3:0] lead, input logic [3:0] rate, input int n);
      int c;
      is_slave = 1'b0; cfg_scrub_off = 1'b0; cfg_bypass = 1'b0;
      cfg_lead_code = lead; cfg_rate_code = rate;
      for (int k = 0; k < n; k++) exp_q.push_back(19'(k));
      cfg_pulse();
      check(scrub_ptr == '1, "R6", "pointer after configuration", scrub_ptr, 19'h7FFFF);
      for (int i = 0; i < n; i++) begin
         count_while_busy_hi(c);
         check(c == 16 * (int'(rate) + 1), "R5", "idle interval", c, 16 * (int'(rate) + 1));
         c = 0;
         while (!busy_n_o && scrub_n_o && c < 5000) begin c++; @(negedge clk); end
         check(c == 4 + 2 * int'(lead), "R2", "busy lead", c, 4 + 2 * int'(lead));
         c = 0;
         while (!scrub_n_o && c < 5000) begin c++; @(negedge clk); end
         check(c == STROBE, "R3", "strobe width", c, STROBE);
         c = 0;
         while (!busy_n_o && c < 5000) begin c++; @(negedge clk); end
         check(c == TAIL, "R4", "busy tail", c, TAIL);
      end
      check(scrub_ptr == 19'(n - 1), "R6", "pointer after scrubs", scrub_ptr, n - 1);
      check(exp_q.size() == 0, "R7", "pending expected scrubs", exp_q.size(), 0);
   endtask

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(busy_n_o && scrub_n_o, "R1", "strobes after reset", {busy_n_o, scrub_n_o}, 2'b11);
      check(!mem_rd && !mem_wr, "R1", "memory requests after reset", {mem_rd, mem_wr}, 0);
      check(scrub_ptr == '1, "R1", "pointer after reset", scrub_ptr, 19'h7FFFF);
      check(!err_flag, "R1", "error flag after reset", err_flag, 0);

      // master, shortest codes; first scrub wraps all ones to 0 (R6)
      run_master(4'd0, 4'd0, 3);

      // master, longer codes, with an error injected at address 1 (R8)
      err_en = 1'b1; err_at = 19'd1;
      run_master(4'd5, 4'd2, 2);
      err_en = 1'b0;
      check(err_flag, "R8", "error flag after faulty scrub", err_flag, 1);
      check(err_addr == 19'd1, "R8", "captured error address", err_addr, 1);

      // disabled by the scrub-off bit (R9); the write also clears the flag (R8)
      cfg_scrub_off = 1'b1;
      cfg_pulse();
      check(!err_flag, "R8", "error flag after configuration", err_flag, 0);
      c = 0;
      for (int i = 0; i < 300; i++) begin
         if (!busy_n_o || !scrub_n_o) c++;
         @(negedge clk);
      end
      check(c == 0, "R9", "busy cycles with scrub off", c, 0);

      // disabled by bypass (R9)
      cfg_scrub_off = 1'b0; cfg_bypass = 1'b1;
      cfg_pulse();
      c = 0;
      for (int i = 0; i < 300; i++) begin
         if (!busy_n_o || !scrub_n_o) c++;
         @(negedge clk);
      end
      check(c == 0, "R9", "busy cycles with bypass", c, 0);
      check(scrub_ptr == '1, "R9", "pointer while bypassed", scrub_ptr, 19'h7FFFF);

      // slave mode (R10)
      is_slave = 1'b1; cfg_bypass = 1'b0;
      cfg_pulse();
      exp_q.push_back(19'd0);
      @(negedge clk) scrub_n_i = 1'b0;
      repeat (6) @(negedge clk);
      scrub_n_i = 1'b1;
      repeat (4) @(negedge clk);
      check(scrub_ptr == 19'd0, "R10", "pointer after first slave strobe", scrub_ptr, 0);
      exp_q.push_back(19'd1);
      @(negedge clk) scrub_n_i = 1'b0;
      repeat (20) @(negedge clk);
      scrub_n_i = 1'b1;
      repeat (200) @(negedge clk);
      check(scrub_ptr == 19'd1, "R10", "pointer after long slave strobe", scrub_ptr, 1);
      check(exp_q.size() == 0, "R10", "pending slave scrubs", exp_q.size(), 0);
      check(!slave_viol, "R10", "slave drove busy or strobe", slave_viol, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule